// File: doc/BRIEF.md
# Programmable-Offset FIFO Status Flag Generator

This block turns the word count of a synchronous FIFO into five active-low status flags. The flags are a low-end flag, almost-empty, half-full, almost-full and a high-end flag. The count comes from one clock domain, and every flag is registered on that same clock. The almost-empty and almost-full thresholds depend on two offset registers. Each offset register resets to a value chosen by the FIFO depth and can be rewritten at run time through a write strobe.

The block has two modes, selected by `fwft_mode`.

- **Standard mode (`fwft_mode` = 0):** the low-end flag means empty and the high-end flag means full.
- **First-word-fall-through mode (`fwft_mode` = 1):** the low-end flag becomes output-ready and the high-end flag becomes input-ready. The word held in the output register counts toward the total, so every threshold sits one word higher and the count can reach DEPTH+1.

Top module: `fifo_flag_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the flags take their zero-word values for the selected mode. Standard mode gives {empty_n, ae_n, hf_n, af_n, full_n} = 0,0,1,1,1. Fall-through mode gives 1,0,1,1,0.
- R2: In standard mode `lo_flag_n` (empty) is low only when the count is 0 and is high for any nonzero count.
- R3: In standard mode `almost_empty_n` is low for counts 0 through n and high above n.
- R4: In standard mode `hi_flag_n` (full) is low only when the count equals DEPTH. `almost_full_n` is low for counts from DEPTH−m up to DEPTH.
- R5: In standard mode `half_full_n` is low when the count exceeds DEPTH/2, which for DEPTH 256 means from 129 words up.
- R6: In fall-through mode `lo_flag_n` (output-ready) is high only at count 0. `hi_flag_n` (input-ready) is high only at DEPTH+1 words.
- R7: In fall-through mode the following flags are low:
  - `almost_empty_n` for counts 0 through n+1;
  - `half_full_n` from DEPTH/2+2 words up;
  - `almost_full_n` from DEPTH+1−m words up.
- R8: The offsets n and m reset to 31 for DEPTH 256, 63 for DEPTH 512 and 127 for larger depths. A high `ae_ofs_we` or `af_ofs_we` at a rising edge loads `ofs_wdata` into n or m respectively. The flags use the new value from the following rising edge.
- R9: The flags are registered. The values present after a rising edge reflect the count and mode sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the domain that owns the count |
| rst | input | 1 | Synchronous active-high reset |
| fwft_mode | input | 1 | 0 selects standard mode, 1 selects first-word-fall-through mode |
| count | input | $clog2(DEPTH)+1 | Number of words currently stored |
| ofs_wdata | input | $clog2(DEPTH)-1 | New offset value |
| ae_ofs_we | input | 1 | Load `ofs_wdata` into the empty offset n |
| af_ofs_we | input | 1 | Load `ofs_wdata` into the full offset m |
| lo_flag_n | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| almost_empty_n | output | 1 | Programmable almost-empty, active low |
| half_full_n | output | 1 | Half-full, active low |
| almost_full_n | output | 1 | Programmable almost-full, active low |
| hi_flag_n | output | 1 | Full (standard) or input-ready (fall-through), active low |

## Verification
Each flag is due one rising edge after the count and mode it reflects are sampled. An offset write is due one edge later again, because it first lands in the offset register. The bench applies its inputs shortly after each rising edge. Its reference model computes the expected flags at that edge from the same sampled values, and the comparison runs at the following falling edge, so every check lines up with the single register stage. Checks that follow a write are tagged to the offset requirement, which confirms the extra edge of delay.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

    typedef struct packed {
        logic lo_n;   // empty / output-ready
        logic ae_n;   // almost empty
        logic hf_n;   // half full
        logic af_n;   // almost full
        logic hi_n;   // full / input-ready
    } flags_t;

    function automatic int default_offset(input int depth);
        if (depth <= 256)      return 31;
        else if (depth <= 512) return 63;
        else                   return 127;
    endfunction

    function automatic flags_t zero_flags(input logic fwft);
        flags_t f;
        f.lo_n = fwft;
        f.ae_n = 1'b0;
        f.hf_n = 1'b1;
        f.af_n = 1'b1;
        f.hi_n = ~fwft;
        return f;
    endfunction

endpackage

// File: rtl/flag_offset_regs.sv
module flag_offset_regs #(
    parameter int OW  = 7,
    parameter int DEF = 31
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ae_we,
    input  logic          af_we,
    input  logic [OW-1:0] wdata,
    output logic [OW-1:0] ae_ofs,
    output logic [OW-1:0] af_ofs
);
    localparam logic [OW-1:0] DEF_V = OW'(DEF);

    always_ff @(posedge clk) begin
        if (rst) begin
            ae_ofs <= DEF_V;
            af_ofs <= DEF_V;
        end else begin
            if (ae_we) ae_ofs <= wdata;
            if (af_we) af_ofs <= wdata;
        end
    end

    // R8: a write strobe loads the presented value
    p_ae_load_r8: assert property (@(posedge clk) disable iff (rst)
        ae_we |=> (ae_ofs == $past(wdata)));
    p_af_load_r8: assert property (@(posedge clk) disable iff (rst)
        af_we |=> (af_ofs == $past(wdata)));
endmodule

// File: rtl/flag_decode.sv
module flag_decode
    import fifo_flag_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CW    = 9,
    parameter int OW    = 7
) (
    input  logic          fwft,
    input  logic [CW-1:0] count,
    input  logic [OW-1:0] ae_ofs,
    input  logic [OW-1:0] af_ofs,
    output flags_t        flags
);
    localparam int TW = CW + 1;
    localparam logic [TW-1:0] HALF_LIM = TW'(DEPTH / 2 + 1);
    localparam logic [TW-1:0] TOP      = TW'(DEPTH);

    logic [TW-1:0] cnt, bias, ae_lim, hf_lim, af_lim, top_lim;
    logic          nonzero, at_top;

    always_comb begin
        cnt     = {1'b0, count};
        bias    = {{(TW-1){1'b0}}, fwft};
        ae_lim  = {{(TW-OW){1'b0}}, ae_ofs} + bias;
        hf_lim  = HALF_LIM + bias;
        af_lim  = TOP - {{(TW-OW){1'b0}}, af_ofs} + bias;
        top_lim = TOP + bias;
        nonzero = (cnt != '0);
        at_top  = (cnt >= top_lim);

        flags.lo_n = fwft ? ~nonzero : nonzero;
        flags.ae_n = ~(cnt <= ae_lim);
        flags.hf_n = ~(cnt >= hf_lim);
        flags.af_n = ~(cnt >= af_lim);
        flags.hi_n = fwft ? at_top : ~at_top;
    end
endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
    import fifo_flag_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CW   = $clog2(DEPTH) + 1,
    localparam int OW   = $clog2(DEPTH) - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_mode,
    input  logic [CW-1:0] count,
    input  logic [OW-1:0] ofs_wdata,
    input  logic          ae_ofs_we,
    input  logic          af_ofs_we,
    output logic          lo_flag_n,
    output logic          almost_empty_n,
    output logic          half_full_n,
    output logic          almost_full_n,
    output logic          hi_flag_n
);
    localparam int DEF_OFS = default_offset(DEPTH);

    logic [OW-1:0] ae_ofs, af_ofs;
    flags_t        next_flags, flags_q;

    flag_offset_regs #(.OW(OW), .DEF(DEF_OFS)) u_ofs (
        .clk    (clk),
        .rst    (rst),
        .ae_we  (ae_ofs_we),
        .af_we  (af_ofs_we),
        .wdata  (ofs_wdata),
        .ae_ofs (ae_ofs),
        .af_ofs (af_ofs)
    );

    flag_decode #(.DEPTH(DEPTH), .CW(CW), .OW(OW)) u_dec (
        .fwft   (fwft_mode),
        .count  (count),
        .ae_ofs (ae_ofs),
        .af_ofs (af_ofs),
        .flags  (next_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) flags_q <= zero_flags(fwft_mode);
        else     flags_q <= next_flags;
    end

    assign lo_flag_n      = flags_q.lo_n;
    assign almost_empty_n = flags_q.ae_n;
    assign half_full_n    = flags_q.hf_n;
    assign almost_full_n  = flags_q.af_n;
    assign hi_flag_n      = flags_q.hi_n;

    // R2: any stored word lifts the standard empty flag
    p_empty_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (!fwft_mode && count != '0) |=> lo_flag_n);
    // R4: a full standard FIFO shows full and almost full
    p_full_at_depth_r4: assert property (@(posedge clk) disable iff (rst)
        (!fwft_mode && count == CW'(DEPTH)) |=> (!hi_flag_n && !almost_full_n));
    // R6: fall-through input-ready goes high at DEPTH+1 words
    p_ir_high_r6: assert property (@(posedge clk) disable iff (rst)
        (fwft_mode && count == CW'(DEPTH + 1)) |=> hi_flag_n);
    // R7: half full never coincides with almost empty (offsets below half depth)
    p_hf_excl_ae_r7: assert property (@(posedge clk) disable iff (rst)
        !half_full_n |-> almost_empty_n);
    // R1: reset yields zero-word values
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (!almost_empty_n && half_full_n && almost_full_n));
endmodule

// File: tb/tb_fifo_flag_gen.sv
module tb_fifo_flag_gen;
    localparam int D  = 256;
    localparam int CW = $clog2(D) + 1;
    localparam int OW = $clog2(D) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fwft_mode = 1'b0;
    logic [CW-1:0] count = '0;
    logic [OW-1:0] ofs_wdata = '0;
    logic          ae_ofs_we = 1'b0;
    logic          af_ofs_we = 1'b0;
    logic lo_flag_n, almost_empty_n, half_full_n, almost_full_n, hi_flag_n;

    int n_chk = 0, n_bad = 0, cycles = 0;
    int m_n, m_m;
    logic [4:0] exp_f;
    bit exp_valid = 0, tag_reset = 0, tag_wr = 0, prev_wr = 0, exp_fw = 0;

    always #5 clk = ~clk;

    fifo_flag_gen #(.DEPTH(D)) dut (
        .clk(clk), .rst(rst), .fwft_mode(fwft_mode), .count(count),
        .ofs_wdata(ofs_wdata), .ae_ofs_we(ae_ofs_we), .af_ofs_we(af_ofs_we),
        .lo_flag_n(lo_flag_n), .almost_empty_n(almost_empty_n),
        .half_full_n(half_full_n), .almost_full_n(almost_full_n),
        .hi_flag_n(hi_flag_n)
    );

    function automatic logic [4:0] ref_flags(int c, bit fw, int n, int m);
        logic e, ae, hf, af, f;
        if (!fw) begin
            e = (c != 0); ae = !(c <= n); hf = !(c > D/2);
            af = !(c >= D - m); f = !(c == D);
        end else begin
            e = (c == 0); ae = !(c <= n + 1); hf = !(c >= D/2 + 2);
            af = !(c >= D + 1 - m); f = (c == D + 1);
        end
        return {e, ae, hf, af, f};
    endfunction

    // reference model, evaluated at each rising edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        exp_fw    = fwft_mode;
        tag_reset = rst;
        tag_wr    = prev_wr;
        if (rst) begin
            exp_f = ref_flags(0, fwft_mode, 0, 0);
            m_n = (D <= 256) ? 31 : (D <= 512) ? 63 : 127;
            m_m = m_n;
            prev_wr = 0;
        end else begin
            exp_f = ref_flags(int'(count), fwft_mode, m_n, m_m);
            if (ae_ofs_we) m_n = int'(ofs_wdata);
            if (af_ofs_we) m_m = int'(ofs_wdata);
            prev_wr = ae_ofs_we || af_ofs_we;
        end
        exp_valid = 1;
    end

    task automatic cmp(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (exp_valid) begin
            if (tag_reset) begin
                cmp("R1 lo flag", lo_flag_n, exp_f[4]);
                cmp("R1 ae", almost_empty_n, exp_f[3]);
                cmp("R1 hf", half_full_n, exp_f[2]);
                cmp("R1 af", almost_full_n, exp_f[1]);
                cmp("R1 hi flag", hi_flag_n, exp_f[0]);
            end else if (tag_wr) begin
                cmp("R8 ae after offset write", almost_empty_n, exp_f[3]);
                cmp("R8 af after offset write", almost_full_n, exp_f[1]);
                cmp("R8/R9 lo flag", lo_flag_n, exp_f[4]);
                cmp("R8/R9 hf", half_full_n, exp_f[2]);
                cmp("R8/R9 hi flag", hi_flag_n, exp_f[0]);
            end else if (!exp_fw) begin
                cmp("R2/R9 empty", lo_flag_n, exp_f[4]);
                cmp("R3/R9 almost empty", almost_empty_n, exp_f[3]);
                cmp("R5/R9 half full", half_full_n, exp_f[2]);
                cmp("R4/R9 almost full", almost_full_n, exp_f[1]);
                cmp("R4/R9 full", hi_flag_n, exp_f[0]);
            end else begin
                cmp("R6/R9 output ready", lo_flag_n, exp_f[4]);
                cmp("R7/R9 almost empty", almost_empty_n, exp_f[3]);
                cmp("R7/R9 half full", half_full_n, exp_f[2]);
                cmp("R7/R9 almost full", almost_full_n, exp_f[1]);
                cmp("R6/R9 input ready", hi_flag_n, exp_f[0]);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic sweep(int top);
        for (int c = 0; c <= top; c++) begin count = CW'(c); tick(); end
        for (int c = top; c >= 0; c--) begin count = CW'(c); tick(); end
    endtask

    task automatic wr_ofs(bit ae, int v);
        ofs_wdata = OW'(v); ae_ofs_we = ae; af_ofs_we = !ae; tick();
        ae_ofs_we = 0; af_ofs_we = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        // standard mode, default offsets
        rst = 1; fwft_mode = 0; #2; tick(); tick();
        rst = 0;
        sweep(D);
        // R8: new offsets, with a count sitting right at the new limits
        count = CW'(5); wr_ofs(1, 5);
        count = CW'(6); tick();
        count = CW'(D - 100); wr_ofs(0, 100);
        count = CW'(D - 101); tick();
        sweep(D);
        wr_ofs(1, 0); wr_ofs(0, 1);
        sweep(D);
        // fall-through mode after reset
        rst = 1; fwft_mode = 1; count = '0; tick(); tick();
        rst = 0;
        sweep(D + 1);
        wr_ofs(1, 100); wr_ofs(0, 3);
        sweep(D + 1);
        // back to standard without reset
        fwft_mode = 0; sweep(D);
        tick();
        finish_run();
    end
endmodule